// File: doc/BRIEF.md
# Dual halfword multiply-accumulate unit

This unit is the arithmetic core for packed fixed-point audio filters. Each issue brings two 32-bit operand words. Each word holds two signed 16-bit samples. The unit forms two signed 16x16 products from those halves, either adds them or subtracts one from the other, and adds that value to an accumulator value supplied with the same issue. The new accumulator value comes back on a registered result port one clock later.

Three mode bits travel with every issue:

- The exchange bit crosses the pairing, so each half of A meets the opposite half of B.
- The subtract bit turns the sum of the products into a difference.
- The short bit limits the accumulation to 32 bits.

Arithmetic never saturates. An overflow wraps in two's complement at the selected width. The unit is fully pipelined and accepts a new issue on every cycle, so a filter loop can stream one packed coefficient/sample pair per clock.

Top module: `dual_mac_unit`

## Requirements
- R1: With exchange=0, the combined value uses products A[15:0]*B[15:0] (first) and A[31:16]*B[31:16] (second); all halves are signed two's complement.
- R2: With exchange=1, the first product is A[15:0]*B[31:16] and the second is A[31:16]*B[15:0].
- R3: With subtract=1, the combined value is the first product minus the second; with subtract=0 it is their sum.
- R4: With short=0, the result is acc_in plus the combined value, modulo 2^64.
- R5: With short=1, result[31:0] is acc_in[31:0] plus the combined value modulo 2^32, result[63:32] is zero, and acc_in[63:32] has no effect.
- R6: res_valid is high in the cycle after an accepted issue (issue_valid and issue_ready both high at a rising edge) and low after any cycle without one.
- R7: issue_ready is high in every cycle from the second clock edge after reset release, so issues may be accepted on consecutive cycles, each giving its own result.
- R8: While rst_n is low, res_valid and issue_ready are low and res_acc is zero.
- R9: res_acc keeps its value after a cycle with no accepted issue.
- R10: No saturation: overflow wraps, e.g. acc 0x7FFFFFFFFFFFFFFF plus two products 0x7FFF*0x7FFF gives 0x800000007FFE0001, and 0x8000*0x8000 twice in short mode gives 0x0000000080000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| issue_valid | input | 1 | An operation is offered this cycle |
| issue_ready | output | 1 | The unit accepts an offered operation |
| issue_a | input | 32 | Packed operand A, two signed halfwords |
| issue_b | input | 32 | Packed operand B, two signed halfwords |
| mode_exchange | input | 1 | Cross the pairing of halves |
| mode_subtract | input | 1 | Difference of products instead of sum |
| mode_short | input | 1 | 32-bit accumulation |
| acc_in | input | 64 | Accumulator value to add to |
| res_valid | output | 1 | res_acc holds a new result |
| res_acc | output | 64 | New accumulator value |

## Verification
The operand patterns use distinct values in all four halves. A wrong pairing, a swapped sign of the second product or a dropped half therefore each produce a different number. The same operands are run through straight and exchanged pairing and through sum and difference, which separates the routing from the combining step. Extreme values (0x7FFF squared into a full accumulator, and 0x8000 squared) set apart wrapping from saturation and show the truncation of the short mode. A non-zero acc_in upper word in short mode shows that those bits are ignored. A streamed run of consecutive issues, followed by idle cycles, shows one-result-per-cycle throughput and that the result is held.

// File: rtl/dmac_pkg.sv
// Package: shared types for the dual halfword multiply-accumulate unit.
// Assumes nothing beyond the mode bits travelling together with an issue.
package dmac_pkg;

    // Operation mode carried with every issue.
    typedef struct packed {
        logic exchange;   // cross pairing of halves
        logic subtract;   // first product minus second
        logic short_acc;  // 32-bit accumulation
    } dmac_mode_t;

    // Number of products formed per issue.
    localparam int unsigned LANES = 2;

endpackage

// File: rtl/dmac_pair_select.sv
// Module: dmac_pair_select
// Routes the halves of the two packed operands to the two multipliers.
// Lane 0 always takes the low half of A, lane 1 the high half of A.
// The B half goes to the same lane, or to the other lane when exchange is set.
// Assumes exactly two halves per word (dmac_pkg::LANES).
module dmac_pair_select #(
    parameter int unsigned HALF_W = 16,
    localparam int unsigned WORD_W = 2 * HALF_W
) (
    input  logic [WORD_W-1:0]                      op_a,
    input  logic [WORD_W-1:0]                      op_b,
    input  logic                                   exchange,
    output logic [dmac_pkg::LANES-1:0][HALF_W-1:0] mul_x,
    output logic [dmac_pkg::LANES-1:0][HALF_W-1:0] mul_y
);

    logic [dmac_pkg::LANES-1:0][HALF_W-1:0] a_halves;
    logic [dmac_pkg::LANES-1:0][HALF_W-1:0] b_halves;

    // Split the packed words into halves.
    always_comb begin
        a_halves = op_a;
        b_halves = op_b;
    end

    for (genvar g = 0; g < dmac_pkg::LANES; g++) begin : g_lane
        localparam int unsigned CROSS = dmac_pkg::LANES - 1 - g;
        // Select the B half that meets A half g.
        always_comb begin
            mul_x[g] = a_halves[g];
            mul_y[g] = exchange ? b_halves[CROSS] : b_halves[g];
        end
    end

endmodule

// File: rtl/dmac_product.sv
// Module: dmac_product
// One signed HALF_W x HALF_W multiplier, full-width result.
// Assumes two's complement inputs; the product cannot overflow its width.
module dmac_product #(
    parameter int unsigned HALF_W = 16,
    localparam int unsigned PROD_W = 2 * HALF_W
) (
    input  logic [HALF_W-1:0] x,
    input  logic [HALF_W-1:0] y,
    output logic [PROD_W-1:0] p
);

    logic signed [PROD_W-1:0] prod_s;

    // Signed multiply of the two halves.
    always_comb begin
        prod_s = PROD_W'($signed(x)) * PROD_W'($signed(y));
        p      = prod_s;
    end

endmodule

// File: rtl/dmac_accumulate.sv
// Module: dmac_accumulate
// Combines the two products (sum or first minus second) and adds the
// result to the accumulator, either over ACC_W bits or over SHORT_W bits
// with the upper bits cleared. Wraps, never saturates.
// Assumes PROD_W <= ACC_W and SHORT_W <= ACC_W.
module dmac_accumulate #(
    parameter int unsigned PROD_W  = 32,
    parameter int unsigned ACC_W   = 64,
    parameter int unsigned SHORT_W = 32,
    localparam int unsigned EXT_W  = ACC_W - PROD_W
) (
    input  logic [PROD_W-1:0] prod_first,
    input  logic [PROD_W-1:0] prod_second,
    input  logic              subtract,
    input  logic              short_acc,
    input  logic [ACC_W-1:0]  acc_in,
    output logic [ACC_W-1:0]  acc_next
);

    logic [ACC_W-1:0]   first_ext;
    logic [ACC_W-1:0]   second_ext;
    logic [ACC_W-1:0]   combined;
    logic [ACC_W-1:0]   long_sum;
    logic [SHORT_W-1:0] short_sum;

    // Sign-extend the products to accumulator width.
    always_comb begin
        first_ext  = {{EXT_W{prod_first[PROD_W-1]}}, prod_first};
        second_ext = {{EXT_W{prod_second[PROD_W-1]}}, prod_second};
    end

    // Sum or difference of the products.
    always_comb begin
        combined = subtract ? (first_ext - second_ext) : (first_ext + second_ext);
    end

    // Wide and narrow accumulations, both wrapping.
    always_comb begin
        long_sum  = acc_in + combined;
        short_sum = acc_in[SHORT_W-1:0] + combined[SHORT_W-1:0];
    end

    if (SHORT_W < ACC_W) begin : g_short_pad
        // Narrow result with the upper bits cleared.
        always_comb begin
            acc_next = short_acc ? {{(ACC_W - SHORT_W){1'b0}}, short_sum} : long_sum;
        end
    end else begin : g_short_full
        // Narrow width equals the full width: both paths agree.
        always_comb begin
            acc_next = short_acc ? short_sum : long_sum;
        end
    end

endmodule

// File: rtl/dual_mac_unit.sv
// Module: dual_mac_unit (top)
// Packed dual signed halfword multiply-accumulate with one-cycle latency.
// Accepts one issue per clock once out of reset; the result register
// and its valid flag update on every accepted issue.
// Assumes synchronous active-low reset.
module dual_mac_unit #(
    parameter int unsigned HALF_W  = 16,
    parameter int unsigned ACC_W   = 64,
    parameter int unsigned SHORT_W = 32,
    localparam int unsigned WORD_W = 2 * HALF_W,
    localparam int unsigned PROD_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    output logic              issue_ready,
    input  logic [WORD_W-1:0] issue_a,
    input  logic [WORD_W-1:0] issue_b,
    input  logic              mode_exchange,
    input  logic              mode_subtract,
    input  logic              mode_short,
    input  logic [ACC_W-1:0]  acc_in,
    output logic              res_valid,
    output logic [ACC_W-1:0]  res_acc
);

    import dmac_pkg::*;

    dmac_mode_t                    mode;
    logic [LANES-1:0][HALF_W-1:0]  mul_x;
    logic [LANES-1:0][HALF_W-1:0]  mul_y;
    logic [LANES-1:0][PROD_W-1:0]  prods;
    logic [ACC_W-1:0]              acc_next;
    logic                          ready_q;
    logic                          accept;

    // Gather the mode bits.
    always_comb begin
        mode.exchange  = mode_exchange;
        mode.subtract  = mode_subtract;
        mode.short_acc = mode_short;
    end

    dmac_pair_select #(.HALF_W(HALF_W)) u_select (
        .op_a     (issue_a),
        .op_b     (issue_b),
        .exchange (mode.exchange),
        .mul_x    (mul_x),
        .mul_y    (mul_y)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_mul
        dmac_product #(.HALF_W(HALF_W)) u_product (
            .x (mul_x[g]),
            .y (mul_y[g]),
            .p (prods[g])
        );
    end

    dmac_accumulate #(
        .PROD_W  (PROD_W),
        .ACC_W   (ACC_W),
        .SHORT_W (SHORT_W)
    ) u_acc (
        .prod_first  (prods[0]),
        .prod_second (prods[1]),
        .subtract    (mode.subtract),
        .short_acc   (mode.short_acc),
        .acc_in      (acc_in),
        .acc_next    (acc_next)
    );

    // Handshake: an issue is taken when offered and ready.
    always_comb begin
        issue_ready = ready_q;
        accept      = issue_valid & ready_q;
    end

    // Ready rises one cycle after reset release and stays high.
    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= 1'b0;
        else        ready_q <= 1'b1;
    end

    // Result register and valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_acc   <= '0;
        end else begin
            res_valid <= accept;
            if (accept) res_acc <= acc_next;
        end
    end

endmodule

// File: rtl/dmac_checker.sv
// Module: dmac_checker
// Temporal properties of dual_mac_unit, bound to every instance.
module dmac_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        issue_valid,
    input logic        issue_ready,
    input logic [31:0] issue_a,
    input logic [31:0] issue_b,
    input logic        mode_exchange,
    input logic        mode_subtract,
    input logic        mode_short,
    input logic [63:0] acc_in,
    input logic        res_valid,
    input logic [63:0] res_acc
);

    // R6: an accepted issue yields a result next cycle
    a_r6_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_ready) |=> res_valid);

    // R6: no result without an accepted issue
    a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue_valid && issue_ready) |=> !res_valid);

    // R7: ready stays high once out of reset
    a_r7_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
        issue_ready |=> issue_ready);

    // R5: short mode leaves the upper word zero
    a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_ready && mode_short) |=> (res_acc[63:32] == 32'h0));

    // R9: result held when nothing is accepted
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue_valid && issue_ready) |=> $stable(res_acc));

    // R4: zero operand in long mode passes the accumulator through
    a_r4_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_ready && !mode_short && issue_a == 32'h0)
        |=> (res_acc == $past(acc_in)));

endmodule

bind dual_mac_unit dmac_checker u_dmac_checker (.*);

// File: tb/dual_mac_unit_test.sv
`timescale 1ns/1ps
module dual_mac_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic        issue_ready;
    logic [31:0] issue_a = '0;
    logic [31:0] issue_b = '0;
    logic        mode_exchange = 1'b0;
    logic        mode_subtract = 1'b0;
    logic        mode_short = 1'b0;
    logic [63:0] acc_in = '0;
    logic        res_valid;
    logic [63:0] res_acc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dual_mac_unit uut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(issue_ready),
        .issue_a(issue_a), .issue_b(issue_b), .mode_exchange(mode_exchange),
        .mode_subtract(mode_subtract), .mode_short(mode_short), .acc_in(acc_in),
        .res_valid(res_valid), .res_acc(res_acc)
    );

    // Reference arithmetic from the requirements.
    function automatic logic [63:0] model(input logic [31:0] a, input logic [31:0] b,
                                          input bit ex, input bit sb, input bit sh,
                                          input logic [63:0] acc);
        longint alo = longint'($signed(a[15:0]));
        longint ahi = longint'($signed(a[31:16]));
        longint blo = longint'($signed(b[15:0]));
        longint bhi = longint'($signed(b[31:16]));
        longint p0 = alo * (ex ? bhi : blo);
        longint p1 = ahi * (ex ? blo : bhi);
        logic [63:0] comb = sb ? 64'(p0 - p1) : 64'(p0 + p1);
        logic [31:0] low = acc[31:0] + comb[31:0];
        if (sh) return {32'h0, low};
        return acc + comb;
    endfunction

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Issue one operation at a falling edge; the result is checked one cycle later.
    task automatic issue_one(input string req, input logic [31:0] a, input logic [31:0] b,
                             input bit ex, input bit sb, input bit sh, input logic [63:0] acc,
                             input logic [63:0] exp);
        issue_a = a; issue_b = b; mode_exchange = ex; mode_subtract = sb;
        mode_short = sh; acc_in = acc; issue_valid = 1'b1;
        @(negedge clk);
        issue_valid = 1'b0;
        check({req, " valid"}, {63'h0, res_valid}, 64'h1);
        check(req, res_acc, exp);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 res_valid", {63'h0, res_valid}, 64'h0);
        check("R8 res_acc", res_acc, 64'h0);
        check("R8 ready", {63'h0, issue_ready}, 64'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R7 ready", {63'h0, issue_ready}, 64'h1);
    endtask

    task automatic t_straight();
        logic [31:0] a = 32'h0003_FFFE;
        logic [31:0] b = 32'h0005_0007;
        issue_one("R1 straight", a, b, 0, 0, 0, 64'h10, model(a, b, 0, 0, 0, 64'h10));
        issue_one("R1 straight neg", 32'hFFF0_0100, 32'h0020_FFFD, 0, 0, 0, 64'h0,
                  model(32'hFFF0_0100, 32'h0020_FFFD, 0, 0, 0, 64'h0));
    endtask

    task automatic t_exchange();
        logic [31:0] a = 32'h0003_FFFE;
        logic [31:0] b = 32'h0005_0007;
        issue_one("R2 exchange", a, b, 1, 0, 0, 64'h10, model(a, b, 1, 0, 0, 64'h10));
    endtask

    task automatic t_subtract();
        logic [31:0] a = 32'h0011_0203;
        logic [31:0] b = 32'h0030_0040;
        issue_one("R3 subtract", a, b, 0, 1, 0, 64'h100, model(a, b, 0, 1, 0, 64'h100));
        issue_one("R3 subtract exchange", a, b, 1, 1, 0, 64'h100, model(a, b, 1, 1, 0, 64'h100));
    endtask

    task automatic t_long();
        issue_one("R4 long carry", 32'h1234_4321, 32'h7000_0F00, 0, 0, 0, 64'h0000_0001_FFFF_FFF0,
                  model(32'h1234_4321, 32'h7000_0F00, 0, 0, 0, 64'h0000_0001_FFFF_FFF0));
    endtask

    task automatic t_short();
        issue_one("R5 short upper ignored", 32'h0100_0200, 32'h0300_0400, 0, 0, 1,
                  64'hDEAD_BEEF_0000_0010, model(32'h0100_0200, 32'h0300_0400, 0, 0, 1, 64'h10));
        issue_one("R5 short wrap", 32'h7FFF_7FFF, 32'h7FFF_7FFF, 0, 0, 1, 64'h0000_0000_7FFF_FFFF,
                  64'h0000_0000_FFFE_0001);
    endtask

    task automatic t_wrap();
        issue_one("R10 long wrap", 32'h7FFF_7FFF, 32'h7FFF_7FFF, 0, 0, 0, 64'h7FFF_FFFF_FFFF_FFFF,
                  64'h8000_0000_7FFE_0001);
        issue_one("R10 min squared short", 32'h8000_8000, 32'h8000_8000, 0, 0, 1, 64'h0,
                  64'h0000_0000_8000_0000);
    endtask

    task automatic t_stream();
        logic [63:0] exp_q [4];
        for (int i = 0; i < 4; i++) begin
            logic [31:0] a = 32'h0101_0202 * (i + 1);
            logic [31:0] b = 32'hFF03_0004 + 32'(i);
            exp_q[i] = model(a, b, i[0], i[1], 0, 64'(i * 7));
            issue_a = a; issue_b = b; mode_exchange = i[0]; mode_subtract = i[1];
            mode_short = 1'b0; acc_in = 64'(i * 7); issue_valid = 1'b1;
            @(negedge clk);
            check("R7 stream valid", {63'h0, res_valid}, 64'h1);
            check("R7 stream result", res_acc, exp_q[i]);
        end
        issue_valid = 1'b0;
        acc_in = 64'hFFFF;
        @(negedge clk);
        check("R6 valid low", {63'h0, res_valid}, 64'h0);
        @(negedge clk);
        check("R9 held", res_acc, exp_q[3]);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_straight();
        t_exchange();
        t_subtract();
        t_long();
        t_short();
        t_wrap();
        t_stream();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule